// File: doc/BRIEF.md
# Serial Instruction-Driven Register Controller

This block is the digital control front end of a converter that is programmed over a serial link. A host drives a serial clock, an active-low select and a data line. Every transaction opens with an 8-bit instruction byte. That byte selects the direction, the number of data bytes that follow and the target register. Inside, the block keeps a 16-bit data word for the converter, a 16-bit command word, and a 24-bit offset correction word and a 24-bit full-scale correction word. The instruction byte itself is held only as the fields of the transfer in progress, and it can never be read back.

The serial pins are synchronised into the system clock domain. A shift state machine walks through the states SH_IDLE, SH_INSTR, SH_WDATA and SH_RDATA:
- SH_IDLE moves to SH_INSTR when select falls.
- SH_INSTR moves to SH_WDATA or SH_RDATA on the eighth rising serial edge.
- SH_WDATA and SH_RDATA return to SH_INSTR after the last data bit, so one select window can hold several transactions.
- A high select sends any state back to SH_IDLE.

A control state machine moves from CT_RESET to CT_NORMAL one clock after reset. It moves from CT_NORMAL to CT_CAL when the command mode field holds the calibrate code. It moves from CT_CAL back to CT_NORMAL when the external calibration engine reports completion. The command word also carries a data-clear bit and a correction-reset bit, and each of these holds its target registers at zero while it is set.

Top module: `serial_regctl`

## Requirements
- R1: After reset, the data, command, offset and full-scale registers read zero, `cal_busy_o` and `cal_req_o` are low and `sdo_o` is low.
- R2: The instruction byte is decoded as follows, and it is shifted most significant bit first, sampled on rising `sclk_i`:
  - Bit 7 selects the direction (1 = read, 0 = write).
  - Bits 6:5 give the data byte count minus one.
  - Bit 4 is ignored.
  - Bits 3:0 give the address: 0 = data, 1 = command, 2 = offset, 3 = full-scale.
- R3: A write shifts in (count×8) bits most significant bit first. The addressed register then takes the received word, zero-extended or truncated to its own width. Writes to addresses 4 to 15 change nothing.
- R4: A read presents, on `sdo_o` and most significant bit first, the low (count×8) bits of the addressed register, zero-extended. Each bit is valid while `sclk_i` is low before its rising edge. Addresses 4 to 15 read as zero.
- R5: Raising `cs_n_i` before a transfer completes aborts it: no register changes, and the next transaction starts with a fresh instruction byte.
- R6: Writing a command word whose mode field (bits 1:0) is 01 enters calibration on the next clock. At that point `cal_busy_o` rises and `cal_req_o` is high for exactly one clock.
- R7: While `cal_busy_o` is high, every register write is ignored, and the command mode field reads 01.
- R8: A `cal_done_i` pulse during calibration does three things: it loads `cal_ofs_i` and `cal_gain_i` into the offset and full-scale registers, it clears the mode field to 00, and it drops `cal_busy_o`. Outside calibration, `cal_done_i` has no effect.
- R9: While command bit 2 is set, the data register is held at zero, starting one clock after the bit is set.
- R10: While command bit 3 is set, the offset and full-scale registers are held at zero, and this overrides both host writes and calibration results.
- R11: Several complete transactions may follow one another inside a single low period of `cs_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock |
| cs_n_i | input | 1 | Active-low transaction select |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host, low outside a read |
| cal_done_i | input | 1 | Calibration engine finished, one-clock pulse |
| cal_ofs_i | input | CAL_W | Offset correction result |
| cal_gain_i | input | CAL_W | Full-scale correction result |
| cal_req_o | output | 1 | One-clock calibration start request |
| cal_busy_o | output | 1 | Calibration in progress |
| dac_code_o | output | DATA_W | Data register contents |
| cmd_o | output | DATA_W | Command register contents |
| ofs_o | output | CAL_W | Offset correction register |
| gain_o | output | CAL_W | Full-scale correction register |

## Verification
The bench builds the block with its defaults: DATA_W = 16, CAL_W = 24 and two synchroniser stages. With these values, a 4-byte read of a 24-bit correction word shows a zero top byte, a 4-byte write to it drops the excess byte, and a 1-byte write to the 16-bit data word zeroes its upper half. With a serial half period of eight system clocks, the synchroniser latency sits well inside each serial phase. This lets the behavioural model predict every register, the busy flag and the count of request pulses, and the bench compares them on every settled clock.

// File: rtl/serial_regctl_pkg.sv
`timescale 1ns/1ps
package serial_regctl_pkg;
    localparam int INSTR_W = 8;
    localparam int CNT_W   = 2;
    localparam int ADDR_W  = 4;
    localparam int XFER_W  = (1 << CNT_W) * 8;

    localparam logic [ADDR_W-1:0] A_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_OFS  = 4'd2;
    localparam logic [ADDR_W-1:0] A_GAIN = 4'd3;

    localparam int C_CLR  = 2;
    localparam int C_CRST = 3;
    localparam logic [1:0] MODE_CAL  = 2'b01;
    localparam logic [1:0] MODE_NORM = 2'b00;

    typedef enum logic [1:0] {SH_IDLE, SH_INSTR, SH_WDATA, SH_RDATA} sh_state_t;
    typedef enum logic [1:0] {CT_RESET, CT_NORMAL, CT_CAL} ct_state_t;
endpackage

// File: rtl/serial_regctl_sync.sv
`timescale 1ns/1ps
module serial_regctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_regctl_shift.sv
`timescale 1ns/1ps
module serial_regctl_shift
    import serial_regctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    input  logic [REG_W-1:0]  rd_word_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [REG_W-1:0]  wr_word_o,
    output logic              sdo_o
);
    localparam int BIT_W = $clog2(XFER_W + 1);
    localparam logic [BIT_W-1:0] INSTR_LAST = BIT_W'(INSTR_W - 1);

    logic sclk_s, cs_n_s, sdi_s, sclk_prev;
    logic rise, cs_act;

    // one synchroniser per serial pin, select idles high
    serial_regctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
        (.clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
    serial_regctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
        (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_n_s));
    serial_regctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi
        (.clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_s));

    sh_state_t              state_q, state_d;
    logic [BIT_W-1:0]       bit_q;
    logic [REG_W-2:0]       in_sr;
    logic [XFER_W-1:0]      out_sr;
    logic [CNT_W-1:0]       cnt_q;
    logic [ADDR_W-1:0]      addr_q;
    logic                   instr_last, data_last;
    logic [BIT_W-1:0]       nb_next;

    function automatic logic [BIT_W-1:0] nbits(input logic [CNT_W-1:0] c);
        return (BIT_W'(c) + BIT_W'(1)) << 3;
    endfunction

    assign rise       = sclk_s & ~sclk_prev;
    assign cs_act     = ~cs_n_s;
    assign instr_last = (bit_q == INSTR_LAST);
    assign data_last  = (bit_q == nbits(cnt_q) - BIT_W'(1));
    // count field of the byte completing now: bits 6:5 sit at in_sr[5:4]
    assign nb_next    = nbits(in_sr[5:4]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (cs_act) state_d = SH_INSTR;
            SH_INSTR: begin
                if (!cs_act)                 state_d = SH_IDLE;
                else if (rise && instr_last) state_d = in_sr[6] ? SH_RDATA : SH_WDATA;
            end
            SH_WDATA, SH_RDATA: begin
                if (!cs_act)                state_d = SH_IDLE;
                else if (rise && data_last) state_d = SH_INSTR;
            end
            default: state_d = SH_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            bit_q     <= '0;
            in_sr     <= '0;
            out_sr    <= '0;
            cnt_q     <= '0;
            addr_q    <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (!cs_act) begin
                bit_q  <= '0;
                in_sr  <= '0;
                out_sr <= '0;
            end else if (rise) begin
                unique case (state_q)
                    SH_INSTR: begin
                        if (instr_last) begin
                            bit_q  <= '0;
                            cnt_q  <= in_sr[5:4];
                            addr_q <= {in_sr[2:0], sdi_s};
                            in_sr  <= '0;
                            out_sr <= XFER_W'(rd_word_i) << (BIT_W'(XFER_W) - nb_next);
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                            in_sr <= {in_sr[REG_W-3:0], sdi_s};
                        end
                    end
                    SH_WDATA: begin
                        bit_q <= data_last ? '0 : bit_q + BIT_W'(1);
                        in_sr <= data_last ? '0 : {in_sr[REG_W-3:0], sdi_s};
                    end
                    SH_RDATA: begin
                        bit_q  <= data_last ? '0 : bit_q + BIT_W'(1);
                        out_sr <= out_sr << 1;
                        if (data_last) in_sr <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sdo_o     = (state_q == SH_RDATA) ? out_sr[XFER_W-1] : 1'b0;
        wr_stb_o  = cs_act && rise && (state_q == SH_WDATA) && data_last;
        wr_addr_o = addr_q;
        wr_word_o = {in_sr, sdi_s};
        rd_addr_o = {in_sr[2:0], sdi_s};
    end
endmodule

// File: rtl/serial_regctl_bank.sv
`timescale 1ns/1ps
module serial_regctl_bank
    import serial_regctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 24,
    parameter int REG_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_word_i,
    input  logic              wr_block_i,
    input  logic              cal_fin_i,
    input  logic [CAL_W-1:0]  cal_ofs_i,
    input  logic [CAL_W-1:0]  cal_gain_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_word_o,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] cmr_o,
    output logic [CAL_W-1:0]  ocr_o,
    output logic [CAL_W-1:0]  fcr_o
);
    logic [DATA_W-1:0] dir_q, cmr_q;
    logic [CAL_W-1:0]  ocr_q, fcr_q;
    logic              we;

    assign we = wr_stb_i & ~wr_block_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            cmr_q <= '0;
            ocr_q <= '0;
            fcr_q <= '0;
        end else begin
            // data word: clear bit wins over host writes
            if (cmr_q[C_CLR])                    dir_q <= '0;
            else if (we && wr_addr_i == A_DATA)  dir_q <= wr_word_i[DATA_W-1:0];

            // command word: end of calibration returns mode to normal
            if (we && wr_addr_i == A_CMD)        cmr_q <= wr_word_i[DATA_W-1:0];
            else if (cal_fin_i)                  cmr_q[1:0] <= MODE_NORM;

            // correction words: reset bit wins, then results, then host
            if (cmr_q[C_CRST]) begin
                ocr_q <= '0;
                fcr_q <= '0;
            end else if (cal_fin_i) begin
                ocr_q <= cal_ofs_i;
                fcr_q <= cal_gain_i;
            end else if (we) begin
                if (wr_addr_i == A_OFS)  ocr_q <= wr_word_i[CAL_W-1:0];
                if (wr_addr_i == A_GAIN) fcr_q <= wr_word_i[CAL_W-1:0];
            end
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_DATA:  rd_word_o = REG_W'(dir_q);
            A_CMD:   rd_word_o = REG_W'(cmr_q);
            A_OFS:   rd_word_o = REG_W'(ocr_q);
            A_GAIN:  rd_word_o = REG_W'(fcr_q);
            default: rd_word_o = '0;
        endcase
    end

    assign dir_o = dir_q;
    assign cmr_o = cmr_q;
    assign ocr_o = ocr_q;
    assign fcr_o = fcr_q;
endmodule

// File: rtl/serial_regctl_ctl.sv
`timescale 1ns/1ps
module serial_regctl_ctl
    import serial_regctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       cal_done_i,
    output logic       cal_req_o,
    output logic       busy_o,
    output logic       wr_block_o,
    output logic       cal_fin_o
);
    ct_state_t state_q, state_d;
    logic      req_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CT_RESET;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= (state_q == CT_NORMAL) && (state_d == CT_CAL);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_RESET:  state_d = CT_NORMAL;
            CT_NORMAL: if (mode_i == MODE_CAL) state_d = CT_CAL;
            CT_CAL:    if (cal_done_i)        state_d = CT_NORMAL;
            default:   state_d = CT_RESET;
        endcase
    end

    // outputs
    always_comb begin
        cal_req_o  = req_q;
        busy_o     = (state_q == CT_CAL);
        wr_block_o = (state_q != CT_NORMAL);
        cal_fin_o  = (state_q == CT_CAL) && cal_done_i;
    end
endmodule

// File: rtl/serial_regctl.sv
`timescale 1ns/1ps
module serial_regctl
    import serial_regctl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CAL_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              cal_done_i,
    input  logic [CAL_W-1:0]  cal_ofs_i,
    input  logic [CAL_W-1:0]  cal_gain_i,
    output logic              cal_req_o,
    output logic              cal_busy_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic [DATA_W-1:0] cmd_o,
    output logic [CAL_W-1:0]  ofs_o,
    output logic [CAL_W-1:0]  gain_o
);
    localparam int REG_W = (CAL_W > DATA_W) ? CAL_W : DATA_W;

    logic [REG_W-1:0]  rd_word, wr_word;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_stb, wr_block, cal_fin;

    serial_regctl_shift #(.SYNC_STAGES(SYNC_STAGES), .REG_W(REG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
        .rd_word_i(rd_word), .rd_addr_o(rd_addr), .wr_stb_o(wr_stb),
        .wr_addr_o(wr_addr), .wr_word_o(wr_word), .sdo_o(sdo_o)
    );

    serial_regctl_bank #(.DATA_W(DATA_W), .CAL_W(CAL_W), .REG_W(REG_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
        .wr_word_i(wr_word), .wr_block_i(wr_block), .cal_fin_i(cal_fin),
        .cal_ofs_i(cal_ofs_i), .cal_gain_i(cal_gain_i), .rd_addr_i(rd_addr),
        .rd_word_o(rd_word), .dir_o(dac_code_o), .cmr_o(cmd_o),
        .ocr_o(ofs_o), .fcr_o(gain_o)
    );

    serial_regctl_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .mode_i(cmd_o[1:0]), .cal_done_i(cal_done_i),
        .cal_req_o(cal_req_o), .busy_o(cal_busy_o), .wr_block_o(wr_block),
        .cal_fin_o(cal_fin)
    );
endmodule

// File: rtl/serial_regctl_chk.sv
`timescale 1ns/1ps
module serial_regctl_chk #(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_req_o,
    input logic              cal_busy_o,
    input logic [DATA_W-1:0] dac_code_o,
    input logic [DATA_W-1:0] cmd_o,
    input logic [CAL_W-1:0]  ofs_o,
    input logic [CAL_W-1:0]  gain_o
);
    // R6
    req_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req_o |-> cal_busy_o);
    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req_o |=> !cal_req_o);
    // R6
    busy_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy_o) |-> cal_req_o);
    // R7
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o |-> cmd_o[1:0] == 2'b01);
    // R7
    busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy_o && $past(cal_busy_o)) |-> ($stable(dac_code_o) && $stable(cmd_o)));
    // R8
    done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy_o) |-> cmd_o[1:0] == 2'b00);
    // R9
    clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_o[2]) |-> dac_code_o == '0);
    // R10
    crst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_o[3]) |-> (ofs_o == '0 && gain_o == '0));
endmodule

bind serial_regctl serial_regctl_chk #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_req_o(cal_req_o), .cal_busy_o(cal_busy_o),
    .dac_code_o(dac_code_o), .cmd_o(cmd_o), .ofs_o(ofs_o), .gain_o(gain_o)
);

// File: tb/serial_regctl_tb_top.sv
`timescale 1ns/1ps
module serial_regctl_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic        cal_done = 1'b0;
    logic [23:0] cal_ofs = '0, cal_gain = '0;
    logic        sdo, cal_req, cal_busy;
    logic [15:0] dac_code, cmd;
    logic [23:0] ofs, gain;

    serial_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
        .sdo_o(sdo), .cal_done_i(cal_done), .cal_ofs_i(cal_ofs), .cal_gain_i(cal_gain),
        .cal_req_o(cal_req), .cal_busy_o(cal_busy), .dac_code_o(dac_code),
        .cmd_o(cmd), .ofs_o(ofs), .gain_o(gain)
    );

    int checks = 0, errors = 0, seen_req = 0, e_req = 0;
    bit settled = 1'b0, ended = 1'b0;
    logic [15:0] e_dir = '0, e_cmd = '0;
    logic [23:0] e_ofs = '0, e_gain = '0;
    bit e_busy = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model holds: clear bit and correction-reset bit
    task automatic model_hold;
        if (e_cmd[2]) e_dir = '0;
        if (e_cmd[3]) begin e_ofs = '0; e_gain = '0; end
    endtask

    task automatic model_write(input logic [3:0] addr, input logic [31:0] w);
        if (e_busy) return;
        case (addr)
            4'd0: e_dir = w[15:0];
            4'd1: begin
                e_cmd = w[15:0];
                if (w[1:0] == 2'b01) begin e_busy = 1'b1; e_req++; end
            end
            4'd2: e_ofs = w[23:0];
            4'd3: e_gain = w[23:0];
            default: ;
        endcase
        model_hold();
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] addr, input int n);
        logic [63:0] m = (64'd1 << n) - 64'd1;
        logic [31:0] v;
        case (addr)
            4'd0: v = {16'h0, e_dir};
            4'd1: v = {16'h0, e_cmd};
            4'd2: v = {8'h0, e_ofs};
            4'd3: v = {8'h0, e_gain};
            default: v = '0;
        endcase
        return v & m[31:0];
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (cal_req) seen_req++;
        if (settled && rst_n && !ended) begin
            chk("R3", "data reg", {16'h0, dac_code}, {16'h0, e_dir});
            chk("R6", "cmd reg", {16'h0, cmd}, {16'h0, e_cmd});
            chk("R8", "offset reg", {8'h0, ofs}, {8'h0, e_ofs});
            chk("R8", "gain reg", {8'h0, gain}, {8'h0, e_gain});
            chk("R7", "busy", {31'h0, cal_busy}, {31'h0, e_busy});
        end
    end

    task automatic bitx(input logic b, output logic s);
        sclk = 1'b0; sdi = b;
        repeat (HALF) @(negedge clk);
        s = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_low;
        settled = 1'b0; cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        settled = 1'b1;
    endtask

    task automatic send(input logic [7:0] ins, input logic [31:0] wd, output logic [31:0] rd);
        int n = (int'(ins[6:5]) + 1) * 8;
        logic [63:0] m = (64'd1 << n) - 64'd1;
        logic s;
        rd = '0;
        for (int i = 7; i >= 0; i--) bitx(ins[i], s);
        for (int i = n - 1; i >= 0; i--) begin
            bitx(ins[7] ? 1'b0 : wd[i], s);
            rd[i] = s;
        end
        if (!ins[7]) model_write(ins[3:0], wd & m[31:0]);
    endtask

    task automatic wr(input logic [7:0] ins, input logic [31:0] wd);
        logic [31:0] dummy;
        cs_low(); send(ins, wd, dummy); cs_high();
    endtask

    task automatic rd_chk(input string req, input logic [7:0] ins);
        logic [31:0] r, e;
        e = model_read(ins[3:0], (int'(ins[6:5]) + 1) * 8);
        cs_low(); send(ins, 32'h0, r); cs_high();
        chk(req, "serial read", r, e);
    endtask

    task automatic cal_fin(input logic [23:0] o, input logic [23:0] g);
        @(negedge clk);
        cal_ofs = o; cal_gain = g; cal_done = 1'b1;
        if (e_busy) begin
            e_busy = 1'b0; e_cmd[1:0] = 2'b00;
            e_ofs = o; e_gain = g;
            model_hold();
        end
        @(negedge clk);
        cal_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up;
        ended = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] r;
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "data after reset", {16'h0, dac_code}, 32'h0);
        chk("R1", "cmd after reset", {16'h0, cmd}, 32'h0);
        chk("R1", "corrections after reset", {8'h0, ofs | gain}, 32'h0);
        chk("R1", "busy/req/sdo after reset", {29'h0, cal_busy, cal_req, sdo}, 32'h0);
        settled = 1'b1;

        // R3 writes of several lengths and targets
        wr(8'h20, 32'h0000A5C3);
        chk("R3", "2-byte data write", {16'h0, dac_code}, 32'h0000A5C3);
        wr(8'h42, 32'h00123456);
        chk("R3", "3-byte offset write", {8'h0, ofs}, 32'h00123456);
        wr(8'h63, 32'hFFABCDEF);
        chk("R3", "4-byte gain write truncates", {8'h0, gain}, 32'h00ABCDEF);
        wr(8'h00, 32'h0000007E);
        chk("R3", "1-byte data write zero-extends", {16'h0, dac_code}, 32'h0000007E);
        wr(8'h67, 32'hDEADBEEF);   // R3 unmapped address, compared every clock
        // R2 bit 4 of the instruction is ignored
        wr(8'h30, 32'h00001357);
        chk("R2", "instr bit4 ignored", {16'h0, dac_code}, 32'h00001357);

        // R4 reads
        rd_chk("R4", 8'hE2);
        rd_chk("R4", 8'h80);
        rd_chk("R4", 8'hA3);
        rd_chk("R4", 8'hA5);
        rd_chk("R4", 8'hA1);

        // R5 abort mid-transfer
        cs_low();
        for (int i = 7; i >= 0; i--) bitx(((8'h20 >> i) & 8'h1) != 0, s);
        for (int i = 0; i < 5; i++) bitx(1'b1, s);
        cs_high();
        chk("R5", "abort leaves data", {16'h0, dac_code}, 32'h00001357);
        wr(8'h20, 32'h00002468);
        chk("R5", "write after abort", {16'h0, dac_code}, 32'h00002468);

        // R11 two transactions in one select window
        cs_low();
        send(8'h20, 32'h00000F0F, r);
        send(8'hA0, 32'h0, r);
        cs_high();
        chk("R11", "read back in same window", r, 32'h00000F0F);

        // R9 clear bit
        wr(8'h21, 32'h00000004);
        chk("R9", "clear zeroes data", {16'h0, dac_code}, 32'h0);
        wr(8'h20, 32'h00001111);
        chk("R9", "write blocked by clear", {16'h0, dac_code}, 32'h0);
        wr(8'h21, 32'h00000000);
        wr(8'h20, 32'h00002222);
        chk("R9", "write after clear off", {16'h0, dac_code}, 32'h00002222);

        // R10 correction reset
        wr(8'h21, 32'h00000008);
        chk("R10", "crst zeroes corrections", {8'h0, ofs | gain}, 32'h0);
        wr(8'h42, 32'h00777777);
        chk("R10", "offset write blocked", {8'h0, ofs}, 32'h0);
        wr(8'h21, 32'h00000000);
        wr(8'h42, 32'h000A0B0C);

        // R6 calibration request
        wr(8'h21, 32'h00000001);
        chk("R6", "busy after cal request", {31'h0, cal_busy}, 32'h1);
        chk("R6", "one request pulse", seen_req, e_req);

        // R7 writes ignored while busy, mode reads 01
        wr(8'h20, 32'h00003333);
        chk("R7", "data frozen while busy", {16'h0, dac_code}, 32'h00002222);
        wr(8'h21, 32'h00000000);
        rd_chk("R7", 8'hA1);

        // R8 completion
        cal_fin(24'h111111, 24'h222222);
        chk("R8", "busy cleared", {31'h0, cal_busy}, 32'h0);
        chk("R8", "mode cleared", {30'h0, cmd[1:0]}, 32'h0);
        chk("R8", "offset loaded", {8'h0, ofs}, 32'h00111111);
        chk("R8", "gain loaded", {8'h0, gain}, 32'h00222222);

        // R10 with calibration: reset bit beats results
        wr(8'h21, 32'h00000009);
        cal_fin(24'h333333, 24'h444444);
        chk("R10", "crst beats cal results", {8'h0, ofs | gain}, 32'h0);
        chk("R10", "cmd after cal with crst", {16'h0, cmd}, 32'h00000008);
        wr(8'h21, 32'h00000000);

        // R8 completion outside calibration has no effect
        cal_fin(24'h000005, 24'h000006);
        chk("R8", "stray done ignored", {8'h0, ofs}, 32'h0);
        chk("R6", "total request pulses", seen_req, e_req);

        repeat (10) @(negedge clk);
        finish_up();
    end
endmodule